// File: doc/BRIEF.md
# I2C Open-Drain Line Driver with Arbitration Monitor

This block sits between an I2C master bit sequencer and the SDA and SCL pads. It never drives a line high. The pad data value of each line is held at zero, and the block changes only the direction control. A line is either turned into an output and pulled low, or turned into an input so that the bus pull-up takes it high. On each cycle the sequencer presents the level it wants on SDA and on SCL. The block registers these levels into the two direction bits and sends the constant-low data values to the pads.

While it is releasing SDA the block watches the bus for other masters. The SDA and SCL inputs pass through a synchronizer. Once the released level has had time to pass through the synchronizer, a low on SDA while SCL reads high means that another master has won the bus. The block then sets both lines to input on that same edge and raises a lost flag. It also records whether the sequencer reported the address phase or the data phase at that moment. A loss in the data phase means the byte must be sent again later. A loss in the address phase means the slave receive path may go on listening and acknowledge its own address. The lines stay released until firmware clears the flag. Driving resumes only when the next transfer is started.

Top module: `i2c_od_arbiter`

## Requirements
- R1: The pad data outputs `sdaOut` and `sclOut` are 0 in every cycle. A line is controlled only by its direction output, where 1 means released (input) and 0 means pulled low (output).
- R2: While a transfer is active and no loss is flagged, `sdaDir` and `sclDir` equal the `sdaReq` and `sclReq` values sampled at the previous rising clock edge.
- R3: Outside an active transfer (after reset, or while the lost flag is set), both direction outputs are 1 whatever the requests are.
- R4: With SDA released and the synchronized SCL high, a low on the SDA pad is reported on `arbLost`. The flag is registered on the (SYNC_STAGES+1)th rising edge after the pad goes low, provided SDA has already been released for at least SYNC_STAGES edges. With the default SYNC_STAGES=2 this is the third edge.
- R5: No loss is detected while SDA is being pulled low by the block, or while synchronized SCL is low.
- R6: On the edge where `arbLost` rises, both `sdaDir` and `sclDir` become 1.
- R7: On a loss, `lostInAddr` takes the value of `addrPhase` (1 = address phase, 0 = data phase). `retryData` equals `arbLost` AND NOT `lostInAddr`. `slaveListen` equals `arbLost` AND `lostInAddr`.
- R8: `arbLost` stays set, and `xferStart` is ignored, until `lostClear` is sampled high. `arbLost` and `lostInAddr` then read 0 after that edge.
- R9: After the flag is cleared, both lines stay released until `xferStart` is sampled high. Requests take effect on the second edge after `xferStart`.
- R10: After reset both direction outputs are 1 and `arbLost`, `lostInAddr`, `retryData` and `slaveListen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xferStart | input | 1 | Pulse that starts a transfer (ignored while lost) |
| addrPhase | input | 1 | 1 while the sequencer sends the address, 0 for data |
| sdaReq | input | 1 | Requested SDA level from the sequencer |
| sclReq | input | 1 | Requested SCL level from the sequencer |
| lostClear | input | 1 | Firmware clear of the lost flag |
| sdaIn | input | 1 | SDA pad level (asynchronous) |
| sclIn | input | 1 | SCL pad level (asynchronous) |
| sdaDir | output | 1 | SDA direction: 1 released, 0 driven |
| sclDir | output | 1 | SCL direction: 1 released, 0 driven |
| sdaOut | output | 1 | SDA pad data value, always 0 |
| sclOut | output | 1 | SCL pad data value, always 0 |
| arbLost | output | 1 | Arbitration lost flag |
| lostInAddr | output | 1 | Phase of the loss: 1 address, 0 data |
| retryData | output | 1 | Loss in data phase: the byte must be resent |
| slaveListen | output | 1 | Loss in address phase: slave path keeps receiving |

## Verification
A request change reaches the direction outputs on the first rising edge after it is applied. A transfer start has its effect on the second edge, because the state must become active first. A pad pulled low by the other master is flagged on the third edge with two synchronizer stages, and the lines are released on that same edge. A lost-flag clear shows one edge later. The bench changes inputs and samples outputs 1 ns after a rising edge. It counts edges explicitly and checks both the cycle before and the cycle at which each result is due, so a one-cycle slip in either direction is reported.

// File: rtl/i2c_od_pkg.sv
package i2c_od_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_LOST   = 2'd2
  } odState_t;

  typedef struct packed {
    logic drive;       // follow sequencer requests
    logic clearPhase;  // wipe recorded loss phase
  } odStrobe_t;
endpackage

// File: rtl/i2c_od_sync.sv
module i2c_od_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_od_datapath.sv
module i2c_od_datapath
  import i2c_od_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  odStrobe_t strobe,
  input  logic      sdaReq,
  input  logic      sclReq,
  input  logic      addrPhase,
  input  logic      sdaIn,
  input  logic      sclIn,
  output logic      sdaDir,
  output logic      sclDir,
  output logic      lostInAddr,
  output logic      arbMiss
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] SETTLE = CNT_W'(SYNC_STAGES);

  logic sdaSync, sclSync;
  logic [CNT_W-1:0] settleCnt;
  logic settled;

  i2c_od_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync));
  i2c_od_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync));

  // Count edges since SDA was released, so the synchronizer holds a
  // sample of the released pad before it is compared.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           settleCnt <= '0;
    else if (!strobe.drive || !sdaDir)   settleCnt <= '0;
    else if (settleCnt != SETTLE)        settleCnt <= settleCnt + 1'b1;
  end

  assign settled = (settleCnt == SETTLE);
  assign arbMiss = strobe.drive && sdaDir && settled && sclSync && !sdaSync;

  // Direction bits: 1 releases the line, 0 pulls it low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaDir <= 1'b1;
      sclDir <= 1'b1;
    end else if (strobe.drive && !arbMiss) begin
      sdaDir <= sdaReq;
      sclDir <= sclReq;
    end else begin
      sdaDir <= 1'b1;
      sclDir <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lostInAddr <= 1'b0;
    else if (arbMiss)           lostInAddr <= addrPhase;
    else if (strobe.clearPhase) lostInAddr <= 1'b0;
  end
endmodule

// File: rtl/i2c_od_control.sv
module i2c_od_control
  import i2c_od_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xferStart,
  input  logic      lostClear,
  input  logic      arbMiss,
  output odStrobe_t strobe,
  output logic      arbLost
);
  odState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (xferStart) stateNext = ST_ACTIVE;
      ST_ACTIVE: if (arbMiss)   stateNext = ST_LOST;
      ST_LOST:   if (lostClear) stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.drive      = (state == ST_ACTIVE);
  assign strobe.clearPhase = (state == ST_LOST) && lostClear;
  assign arbLost           = (state == ST_LOST);
endmodule

// File: rtl/i2c_od_arbiter.sv
module i2c_od_arbiter
  import i2c_od_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic xferStart,
  input  logic addrPhase,
  input  logic sdaReq,
  input  logic sclReq,
  input  logic lostClear,
  input  logic sdaIn,
  input  logic sclIn,
  output logic sdaDir,
  output logic sclDir,
  output logic sdaOut,
  output logic sclOut,
  output logic arbLost,
  output logic lostInAddr,
  output logic retryData,
  output logic slaveListen
);
  odStrobe_t strobe;
  logic arbMiss;

  i2c_od_control u_ctl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .lostClear(lostClear),
    .arbMiss(arbMiss), .strobe(strobe), .arbLost(arbLost));

  i2c_od_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaReq(sdaReq),
    .sclReq(sclReq), .addrPhase(addrPhase), .sdaIn(sdaIn), .sclIn(sclIn),
    .sdaDir(sdaDir), .sclDir(sclDir), .lostInAddr(lostInAddr),
    .arbMiss(arbMiss));

  assign sdaOut      = 1'b0;
  assign sclOut      = 1'b0;
  assign retryData   = arbLost && !lostInAddr;
  assign slaveListen = arbLost && lostInAddr;
endmodule

// File: rtl/i2c_od_arbiter_chk.sv
module i2c_od_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic lostClear,
  input logic sdaDir,
  input logic sclDir,
  input logic sdaOut,
  input logic sclOut,
  input logic arbLost,
  input logic lostInAddr,
  input logic retryData,
  input logic slaveListen
);
  a_r1_pads_low: assert property (@(posedge clk) disable iff (!rstN)
    !sdaOut && !sclOut);

  a_r3_released_while_lost: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> (sdaDir && sclDir));

  a_r5_no_loss_when_driving: assert property (@(posedge clk) disable iff (!rstN)
    (!sdaDir && !arbLost) |=> !arbLost);

  a_r6_release_on_loss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> (sdaDir && sclDir));

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> $onehot({retryData, slaveListen}));

  a_r7_no_outcome_idle: assert property (@(posedge clk) disable iff (!rstN)
    !arbLost |-> (!retryData && !slaveListen));

  a_r8_hold_flag: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !lostClear) |=> (arbLost && $stable(lostInAddr)));

  a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && lostClear) |=> (!arbLost && !lostInAddr));

  a_r9_released_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(arbLost) |-> (sdaDir && sclDir));
endmodule

bind i2c_od_arbiter i2c_od_arbiter_chk u_chk (.*);

// File: tb/i2c_od_arbiter_tb.sv
`timescale 1ns/100ps
module i2c_od_arbiter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xferStart = 1'b0, addrPhase = 1'b0, sdaReq = 1'b1, sclReq = 1'b1;
  logic lostClear = 1'b0;
  logic otherSda = 1'b1, otherScl = 1'b1;
  logic sdaIn, sclIn;
  logic sdaDir, sclDir, sdaOut, sclOut, arbLost, lostInAddr, retryData, slaveListen;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain bus: low if either side pulls low
  assign sdaIn = sdaDir & otherSda;
  assign sclIn = sclDir & otherScl;

  i2c_od_arbiter u_dut (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .addrPhase(addrPhase),
    .sdaReq(sdaReq), .sclReq(sclReq), .lostClear(lostClear),
    .sdaIn(sdaIn), .sclIn(sclIn), .sdaDir(sdaDir), .sclDir(sclDir),
    .sdaOut(sdaOut), .sclOut(sclOut), .arbLost(arbLost),
    .lostInAddr(lostInAddr), .retryData(retryData), .slaveListen(slaveListen));

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {sdaDir,sclDir,sdaOut,sclOut,arbLost,lostInAddr,retryData,slaveListen}
  function automatic logic [7:0] outs();
    return {sdaDir, sclDir, sdaOut, sclOut, arbLost, lostInAddr, retryData, slaveListen};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    #1;
    chk("R10 reset outputs", outs(), 8'b1100_0000);

    // R3: idle ignores requests
    sdaReq = 1'b0; sclReq = 1'b0;
    step(2);
    chk("R3 idle released", {6'b0, sdaDir, sclDir}, 8'd3);

    // start transfer: active after 1st edge, requests show after 2nd (R9 timing too)
    xferStart = 1'b1; step(); xferStart = 1'b0;
    chk("R2 not yet following", {6'b0, sdaDir, sclDir}, 8'd3);
    step();
    chk("R2 following", {6'b0, sdaDir, sclDir}, 8'd0);

    // R2 sweep of all request combinations, one-edge latency
    for (int v = 0; v < 4; v++) begin
      sdaReq = v[1]; sclReq = v[0];
      #0;
      chk("R2 before edge", {6'b0, sdaDir, sclDir}, (v == 0) ? 8'd0 : 8'(v - 1));
      step();
      chk("R2 after edge", {6'b0, sdaDir, sclDir}, 8'(v));
      chk("R1 pads low", {6'b0, sdaOut, sclOut}, 8'd0);
    end

    // address-phase loss: both released, settle
    addrPhase = 1'b1; sdaReq = 1'b1; sclReq = 1'b1;
    step(4);
    chk("R4 no loss on free bus", {7'b0, arbLost}, 8'd0);
    otherSda = 1'b0;
    step(2);
    chk("R4 not before third edge", {7'b0, arbLost}, 8'd0);
    step();
    chk("R4 loss on third edge", {7'b0, arbLost}, 8'd1);
    chk("R6 both released", {6'b0, sdaDir, sclDir}, 8'd3);
    chk("R7 address outcome", {4'b0, lostInAddr, retryData, slaveListen, 1'b0}, 8'b0000_1010);

    // R8: hold, ignore start
    sdaReq = 1'b0; sclReq = 1'b0; otherSda = 1'b1;
    xferStart = 1'b1; step(); xferStart = 1'b0;
    step(3);
    chk("R8 flag held", {7'b0, arbLost}, 8'd1);
    chk("R8 start ignored", {6'b0, sdaDir, sclDir}, 8'd3);
    lostClear = 1'b1; step(); lostClear = 1'b0;
    chk("R8 cleared", {6'b0, arbLost, lostInAddr}, 8'd0);
    step(3);
    chk("R9 released after clear", {6'b0, sdaDir, sclDir}, 8'd3);

    // R9 restart, then R5: driving SDA low while other pulls low
    xferStart = 1'b1; step(); xferStart = 1'b0;
    step();
    chk("R9 driving again", {6'b0, sdaDir, sclDir}, 8'd0);
    sclReq = 1'b1; otherSda = 1'b0;
    step(6);
    chk("R5 no loss driving low", {7'b0, arbLost}, 8'd0);

    // R5: SCL low, SDA released, other pulls SDA low
    sclReq = 1'b0; step(4);
    sdaReq = 1'b1; step(6);
    chk("R5 no loss with SCL low", {7'b0, arbLost}, 8'd0);
    chk("R5 SDA released", {7'b0, sdaDir}, 8'd1);

    // data-phase loss: SDA pad already low, raise SCL with SDA driven low
    sdaReq = 1'b0; sclReq = 1'b1; step(4);
    addrPhase = 1'b0; sdaReq = 1'b1;
    step(3);
    chk("R4 settle wait", {7'b0, arbLost}, 8'd0);
    step();
    chk("R4 data loss flagged", {7'b0, arbLost}, 8'd1);
    chk("R7 data outcome", {5'b0, lostInAddr, retryData, slaveListen}, 8'b0000_0010);
    chk("R6 released data loss", {6'b0, sdaDir, sclDir}, 8'd3);

    // reset mid-loss
    rstN = 1'b0; #1;
    chk("R10 async reset", outs(), 8'b1100_0000);
    step(); rstN = 1'b1; step();
    chk("R1 pads low after reset", {6'b0, sdaOut, sclOut}, 8'd0);

    finish();
  end
endmodule